// File: doc/BRIEF.md
# Brownout Supervisor Control

This block sits between the supply-monitor comparators and the rest of the chip. It turns their raw flags into three outputs: a brownout reset request, a brownout interrupt, and a write-protect signal for the non-volatile memory. Two selectable trip ladders feed it, one for the reset function and one for the interrupt function, and a single fixed-threshold flag feeds the memory-protect function. The ladder arrives as a thermometer code, one bit per trip level. Bit k is high when the supply is below trip level k. Level 0 is the highest trip voltage, so a set bit implies that every lower-indexed bit is also set. A separate flag reports the supply against the fixed memory threshold, nominally 2.4 V.

Each comparator bit goes through a two-stage synchronizer. It then goes through a stability filter, so a bit must hold a new value for four consecutive clocks before the block accepts it. Each of the three functions is then gated by the current power mode. The reset function cannot be turned off; it drops out only in total power-down. The interrupt function keeps a sticky flag, and a software enable gates only the interrupt line. Memory protection runs only while the core is running or idle.

Top module: `bod_ctrl`

## Requirements
- R1: After a synchronous reset, `rst_req_o`, `irq_o`, `irq_flag_o` and `prot_o` are all 0.
- R2: `rst_req_o` equals the filtered ladder bit chosen by `rst_sel_i`. In total power-down it is forced to 0. Power modes on `pmode_i` are encoded as 0 run, 1 idle, 2 power-down and 3 total power-down. A change of `pmode_i` shows on the outputs one clock later.
- R3: `irq_flag_o` sets on the rising edge of (the filtered ladder bit chosen by `irq_sel_i` AND not total power-down). It stays set until `irq_clr_i` is sampled high. If a set edge and a clear arrive in the same cycle, the set wins. Clearing while the condition stays high does not set the flag again.
- R4: `irq_o` is `irq_flag_o` gated by `irq_en_i`. The enable has no effect on whether the flag sets.
- R5: `prot_o` follows the filtered fixed-threshold flag in run and idle. In power-down and total power-down it is 0.
- R6: A comparator change that stays steady appears on the outputs exactly 7 rising clock edges after the first edge that samples it: 2 synchronizer stages, 4 stability clocks and 1 output register.
- R7: A comparator pulse shorter than 4 clocks after synchronization never changes any output. A pulse of exactly 4 clocks does pass.
- R8: The thermometer ladder is `lvl_below_i`. Bit k high means the supply is below trip level k, and a select value k on `rst_sel_i` or `irq_sel_i` picks bit k.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| lvl_below_i | input | 4 | Thermometer ladder of trip-level comparator flags (asynchronous) |
| flash_below_i | input | 1 | Supply below the fixed memory threshold (asynchronous) |
| rst_sel_i | input | 2 | Trip level chosen for the reset function |
| irq_sel_i | input | 2 | Trip level chosen for the interrupt function |
| irq_en_i | input | 1 | Software interrupt enable |
| irq_clr_i | input | 1 | Clears the sticky interrupt flag |
| pmode_i | input | 2 | Power mode: 0 run, 1 idle, 2 power-down, 3 total power-down |
| rst_req_o | output | 1 | Brownout reset request |
| irq_o | output | 1 | Brownout interrupt request |
| irq_flag_o | output | 1 | Sticky brownout interrupt flag |
| prot_o | output | 1 | Non-volatile memory write protect |

## Verification
A change on a comparator input is due at the outputs on the seventh rising edge after it is driven. Changes of mode, select, enable or clear are due on the first edge. The bench drives inputs on the falling edge. The table vectors each hold for ten clocks, which is more than seven, before the outputs are sampled on a falling edge. The directed latency, set-versus-clear and mode-switch tests count the edges exactly: they sample one falling edge before the due edge and one after it, so an extra or a missing register stage is caught.

// File: rtl/bod_pkg.sv
package bod_pkg;
  typedef enum logic [1:0] {
    PM_RUN  = 2'd0,
    PM_IDLE = 2'd1,
    PM_PD   = 2'd2,
    PM_TPD  = 2'd3
  } pmode_e;
endpackage

// File: rtl/bod_sync.sv
module bod_sync #(
  parameter int W      = 1,
  parameter int STAGES = 2
) (
  input  logic         clk,
  input  logic         rst,
  input  logic [W-1:0] d_i,
  output logic [W-1:0] q_o
);
  logic [W-1:0] stg [STAGES];

  always_ff @(posedge clk) begin
    if (rst) begin
      for (int i = 0; i < STAGES; i++) stg[i] <= '0;
    end else begin
      stg[0] <= d_i;
      for (int i = 1; i < STAGES; i++) stg[i] <= stg[i-1];
    end
  end

  assign q_o = stg[STAGES-1];
endmodule

// File: rtl/bod_filt.sv
module bod_filt #(
  parameter int STABLE = 4
) (
  input  logic clk,
  input  logic rst,
  input  logic d_i,
  output logic q_o
);
  localparam int CW = (STABLE > 1) ? $clog2(STABLE) : 1;
  localparam logic [CW-1:0] LAST = CW'(STABLE - 1);

  logic [CW-1:0] cnt;

  always_ff @(posedge clk) begin
    if (rst) begin
      q_o <= 1'b0;
      cnt <= '0;
    end else if (d_i == q_o) begin
      cnt <= '0;
    end else if (cnt == LAST) begin
      q_o <= d_i;
      cnt <= '0;
    end else begin
      cnt <= cnt + 1'b1;
    end
  end

  // R7: the output moves only after the input has differed for the full run
  a_r7_change_after_run: assert property (@(posedge clk) disable iff (rst)
    !$stable(q_o) |-> $past(cnt) == LAST);

  // R7: an input that agrees with the output leaves it untouched
  a_r7_hold_when_equal: assert property (@(posedge clk) disable iff (rst)
    (d_i == q_o) |=> $stable(q_o));
endmodule

// File: rtl/bod_sel.sv
module bod_sel #(
  parameter int SEL_W = 2
) (
  input  logic [(1<<SEL_W)-1:0] lvl_i,
  input  logic [SEL_W-1:0]      sel_i,
  output logic                  hit_o
);
  assign hit_o = lvl_i[sel_i];
endmodule

// File: rtl/bod_ctrl.sv
module bod_ctrl
  import bod_pkg::*;
#(
  parameter int SEL_W       = 2,
  parameter int SYNC_STAGES = 2,
  parameter int STABLE      = 4
) (
  input  logic                  clk,
  input  logic                  rst,
  input  logic [(1<<SEL_W)-1:0] lvl_below_i,
  input  logic                  flash_below_i,
  input  logic [SEL_W-1:0]      rst_sel_i,
  input  logic [SEL_W-1:0]      irq_sel_i,
  input  logic                  irq_en_i,
  input  logic                  irq_clr_i,
  input  logic [1:0]            pmode_i,
  output logic                  rst_req_o,
  output logic                  irq_o,
  output logic                  irq_flag_o,
  output logic                  prot_o
);
  localparam int NLVL = 1 << SEL_W;
  localparam int NF   = NLVL + 1;

  logic [NF-1:0]   raw, syn, filt;
  logic [NLVL-1:0] lvl_f;
  logic            rst_hit, irq_hit;
  pmode_e          pm;
  logic            det_on, mem_on;
  logic            irq_cond, cond_q, rise, flag_d;

  assign raw = {flash_below_i, lvl_below_i};

  bod_sync #(.W(NF), .STAGES(SYNC_STAGES)) u_sync (
    .clk (clk), .rst (rst), .d_i (raw), .q_o (syn)
  );

  for (genvar g = 0; g < NF; g++) begin : g_filt
    bod_filt #(.STABLE(STABLE)) u_filt (
      .clk (clk), .rst (rst), .d_i (syn[g]), .q_o (filt[g])
    );
  end

  assign lvl_f = filt[NLVL-1:0];

  bod_sel #(.SEL_W(SEL_W)) u_sel_rst (
    .lvl_i (lvl_f), .sel_i (rst_sel_i), .hit_o (rst_hit)
  );
  bod_sel #(.SEL_W(SEL_W)) u_sel_irq (
    .lvl_i (lvl_f), .sel_i (irq_sel_i), .hit_o (irq_hit)
  );

  assign pm       = pmode_e'(pmode_i);
  assign det_on   = (pm != PM_TPD);
  assign mem_on   = (pm == PM_RUN) || (pm == PM_IDLE);
  assign irq_cond = irq_hit & det_on;
  assign rise     = irq_cond & ~cond_q;
  assign flag_d   = rise ? 1'b1 : (irq_clr_i ? 1'b0 : irq_flag_o);

  always_ff @(posedge clk) begin
    if (rst) begin
      rst_req_o  <= 1'b0;
      prot_o     <= 1'b0;
      cond_q     <= 1'b0;
      irq_flag_o <= 1'b0;
      irq_o      <= 1'b0;
    end else begin
      rst_req_o  <= rst_hit & det_on;
      prot_o     <= filt[NLVL] & mem_on;
      cond_q     <= irq_cond;
      irq_flag_o <= flag_d;
      irq_o      <= flag_d & irq_en_i;
    end
  end

  // R2: total power-down removes the reset request on the next edge
  a_r2_tpd_no_reset: assert property (@(posedge clk) disable iff (rst)
    (pmode_i == 2'd3) |=> !rst_req_o);

  // R5: power-down modes drop write protection
  a_r5_pd_no_prot: assert property (@(posedge clk) disable iff (rst)
    pmode_i[1] |=> !prot_o);

  // R4: the interrupt line never rises without the flag
  a_r4_irq_needs_flag: assert property (@(posedge clk) disable iff (rst)
    irq_o |-> irq_flag_o);

  // R4: a disabled interrupt stays low
  a_r4_disabled_quiet: assert property (@(posedge clk) disable iff (rst)
    !irq_en_i |=> !irq_o);

  // R3: flag holds until cleared
  a_r3_flag_sticky: assert property (@(posedge clk) disable iff (rst)
    (irq_flag_o && !irq_clr_i) |=> irq_flag_o);

  // R3: flag rises only on a new condition edge
  a_r3_set_on_edge: assert property (@(posedge clk) disable iff (rst)
    $rose(irq_flag_o) |-> $past(irq_cond) && !$past(cond_q));
endmodule

// File: tb/tb_bod_ctrl.sv
`timescale 1ns/1ps
module tb_bod_ctrl;
  logic       clk = 1'b0;
  logic       rst;
  logic [3:0] lvl;
  logic       fl;
  logic [1:0] rsel, isel, pm;
  logic       en, clr;
  logic       rst_req, irq, flag, prot;

  int n_chk = 0;
  int n_bad = 0;
  bit done  = 1'b0;

  always #10 clk = ~clk;

  bod_ctrl dut (
    .clk (clk), .rst (rst), .lvl_below_i (lvl), .flash_below_i (fl),
    .rst_sel_i (rsel), .irq_sel_i (isel), .irq_en_i (en), .irq_clr_i (clr),
    .pmode_i (pm), .rst_req_o (rst_req), .irq_o (irq),
    .irq_flag_o (flag), .prot_o (prot)
  );

  // [15:12] lvl [11] fl [10:9] rsel [8:7] isel [6] en [5:4] pm
  // [3] rst_req [2] irq [1] prot [0] flag
  localparam logic [15:0] VEC [8] = '{
    16'b0000_0_00_00_1_00_0000,
    16'b0001_0_00_01_1_00_1000,
    16'b0011_1_10_01_1_00_0111,
    16'b0111_1_11_10_0_01_0011,
    16'b1111_1_11_11_1_10_1101,
    16'b1111_1_00_00_1_11_0000,
    16'b0001_1_01_00_1_01_0111,
    16'b0000_1_00_00_1_00_0010
  };

  task automatic chk(input logic got, input logic exp, input string req, input string what);
    n_chk++;
    if (got !== exp) begin
      n_bad++;
      $display("FAIL %s %s: got %b expected %b", req, what, got, exp);
    end
  endtask

  task automatic clean();
    lvl = 4'b0; fl = 1'b0; pm = 2'd0; en = 1'b1;
    repeat (10) @(negedge clk);
    clr = 1'b1; @(negedge clk); clr = 1'b0; @(negedge clk);
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1'b1;
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
      $finish;
    end
  endtask

  initial begin
    #(200000 * 20);
    n_chk++; n_bad++;
    $display("FAIL watchdog: got timeout expected completion");
    finish_run();
  end

  initial begin
    int seen;
    rst = 1'b1; lvl = '0; fl = 0; rsel = 0; isel = 0; en = 0; clr = 0; pm = 0;
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    chk(rst_req, 1'b0, "R1", "reset rst_req");
    chk(irq,     1'b0, "R1", "reset irq");
    chk(flag,    1'b0, "R1", "reset flag");
    chk(prot,    1'b0, "R1", "reset prot");

    // table walk: R2 R3 R4 R5 R8
    for (int i = 0; i < 8; i++) begin
      clean();
      lvl = VEC[i][15:12]; fl = VEC[i][11]; rsel = VEC[i][10:9];
      isel = VEC[i][8:7]; en = VEC[i][6]; pm = VEC[i][5:4];
      repeat (10) @(negedge clk);
      chk(rst_req, VEC[i][3], "R2", $sformatf("vec %0d rst_req", i));
      chk(irq,     VEC[i][2], "R4", $sformatf("vec %0d irq", i));
      chk(prot,    VEC[i][1], "R5", $sformatf("vec %0d prot", i));
      chk(flag,    VEC[i][0], "R3", $sformatf("vec %0d flag", i));
    end

    // R6: exact latency
    clean();
    rsel = 2'd0; lvl = 4'b0001;
    repeat (6) @(negedge clk);
    chk(rst_req, 1'b0, "R6", "rst_req before edge 7");
    @(negedge clk);
    chk(rst_req, 1'b1, "R6", "rst_req at edge 7");

    // R2: mode gating takes one edge
    pm = 2'd3; @(negedge clk);
    chk(rst_req, 1'b0, "R2", "tpd drops reset");
    pm = 2'd2; @(negedge clk);
    chk(rst_req, 1'b1, "R2", "power-down keeps reset");

    // R7: 3-clock glitch ignored, 4-clock pulse passes
    clean();
    lvl = 4'b0001; repeat (3) @(negedge clk); lvl = 4'b0000;
    seen = 0;
    for (int k = 0; k < 15; k++) begin @(negedge clk); if (rst_req) seen++; end
    chk(seen != 0, 1'b0, "R7", "3-clock glitch reached rst_req");
    lvl = 4'b0001; repeat (4) @(negedge clk); lvl = 4'b0000;
    seen = 0;
    for (int k = 0; k < 15; k++) begin @(negedge clk); if (rst_req) seen++; end
    chk(seen != 0, 1'b1, "R7", "4-clock pulse reached rst_req");

    // R3: set wins over a simultaneous clear
    clean();
    isel = 2'd1; lvl = 4'b0011;
    repeat (6) @(negedge clk);
    chk(flag, 1'b0, "R3", "flag before edge 7");
    clr = 1'b1; @(negedge clk); clr = 1'b0;
    chk(flag, 1'b1, "R3", "set beats clear");
    // clearing while condition stays high does not re-set
    clr = 1'b1; @(negedge clk); clr = 1'b0;
    repeat (3) @(negedge clk);
    chk(flag, 1'b0, "R3", "clear while condition high");
    // sticky after condition drops
    clean();
    lvl = 4'b0011; repeat (10) @(negedge clk);
    lvl = 4'b0000; repeat (10) @(negedge clk);
    chk(flag, 1'b1, "R3", "flag sticky after recovery");
    chk(irq,  1'b1, "R4", "irq follows sticky flag");
    en = 1'b0; @(negedge clk);
    chk(irq,  1'b0, "R4", "enable off masks irq");
    chk(flag, 1'b1, "R4", "enable off keeps flag");

    finish_run();
  end
endmodule